// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block is the controller-side engine that delivers codec commands from a circular ring in system memory. Software programs a 64-bit ring base address and a ring-size code. It then fills ring entries and moves a write pointer forward. The engine follows with its own read pointer. It fetches each new 32-bit entry through a request/response memory read port and holds it for a serial-link framer. The framer offers one command slot per link frame.

Pointers advance before use. Software first increments the write pointer and then stores the entry at the new index, so the write pointer always names the last valid entry. The engine fetches the entries from read pointer + 1 up to and including the write pointer, modulo the ring size. Before a ring is started, software resets the read pointer with a two-phase handshake. The run bit in the control register reports whether the fetch engine is actually active, not just what software last wrote to it. While the controller is powered down, both pointer registers read as all ones.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset, cmd_valid and mem_req_valid are 0 and cmd_data is 0. The write pointer (offset 3), the read pointer (offset 4) and the control register (offset 5) all read 0.
- R2: Each fetch reads the entry at index (rp+1) mod size from byte address base + 4*index. A fetched entry is later presented on cmd_data with cmd_valid=1, and entries are presented in ring order. A pending memory request holds its address until mem_req_ready.
- R3: The size register (offset 2, bits 1:0) selects the ring length: code 0 gives 2 entries, code 1 gives 16 and code 2 gives 256. The read pointer wraps modulo that length, and it only ever steps by one or is reset to 0.
- R4: No fetch is issued while rp equals wp. The read pointer stops at the write pointer and never passes it.
- R5: The read pointer register holds bits 7:0 = pointer and bit 15 = reset. Writing bit 15 = 1 forces the pointer to 0, and the register then reads 0x8000. No fetch starts while the reset bit is set. A later write with bit 15 = 0 clears it, after which the register reads 0x0000 and fetching may resume.
- R6: Control register bit 0 is the run bit. Writing 1 starts fetching. After 0 is written, no new fetch starts, but the bit keeps reading 1 until any outstanding fetch has returned; it then reads 0.
- R7: While low_power is 1, the write pointer and read pointer registers read 0x0000FFFF. The registers keep their values and read normally again once low_power falls.
- R8: The engine holds at most one fetched entry and starts no new fetch until the framer has taken it on a cycle with cmd_ready=1. When no entry is held, cmd_valid is 0 and the command offered is the all-zero null command.
- R9: The base address is formed from two 32-bit registers: the lower half at offset 0 and the upper half at offset 1. The memory request address carries all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_power | input | 1 | Controller is in a low-power state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Memory read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word, assembled little-endian |
| cmd_ready | input | 1 | Framer takes a command this cycle (one per frame) |
| cmd_valid | output | 1 | A ring entry is offered |
| cmd_data | output | 32 | Offered command; zero when none is held |

## Verification
A corrupted read pointer shows up at once on the memory port: the next request carries a wrong address, and the pointer register reads back the bad value. A pointer that overruns shows up as extra requests within one memory latency after the ring has drained. A stuck entry buffer shows up within one frame, because the offered command either stays frozen or stays null. A faulty outstanding-fetch flag makes the run bit read back wrongly while a slow memory response is pending.

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch #(
  parameter int PTR_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        low_power,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        cmd_ready,
  output logic        cmd_valid,
  output logic [31:0] cmd_data
);
  localparam logic [2:0] A_BLO = 3'd0, A_BHI = 3'd1, A_SIZE = 3'd2,
                         A_WP = 3'd3, A_RP = 3'd4, A_CTL = 3'd5;

  logic [31:0]      base_lo, base_hi;
  logic [1:0]       size_code;
  logic [PTR_W-1:0] wp, rp, rp_mask, rp_nxt;
  logic             rp_rst, run_req, inflight, drop;
  logic             hold_valid;
  logic [31:0]      hold_data;
  logic             can_fetch;

  always_comb begin
    case (size_code)
      2'd0:    rp_mask = PTR_W'(1);
      2'd1:    rp_mask = PTR_W'(15);
      default: rp_mask = {PTR_W{1'b1}};
    endcase
  end

  assign rp_nxt    = (rp + PTR_W'(1)) & rp_mask;
  assign can_fetch = run_req && !rp_rst && !inflight && !hold_valid && (rp != wp);
  assign cmd_valid = hold_valid;
  assign cmd_data  = hold_valid ? hold_data : 32'd0;

  always_comb begin
    case (reg_addr)
      A_BLO:   reg_rdata = base_lo;
      A_BHI:   reg_rdata = base_hi;
      A_SIZE:  reg_rdata = {30'd0, size_code};
      A_WP:    reg_rdata = low_power ? 32'h0000_FFFF : 32'(wp);
      A_RP:    reg_rdata = low_power ? 32'h0000_FFFF : {16'd0, rp_rst, 15'(rp)};
      A_CTL:   reg_rdata = {31'd0, run_req | inflight};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo <= '0; base_hi <= '0; size_code <= '0;
      wp <= '0; rp <= '0; rp_rst <= 1'b0; run_req <= 1'b0;
      inflight <= 1'b0; drop <= 1'b0;
      mem_req_valid <= 1'b0; mem_req_addr <= '0;
      hold_valid <= 1'b0; hold_data <= '0;
    end else begin
      if (can_fetch) begin
        mem_req_valid <= 1'b1;
        mem_req_addr  <= {base_hi, base_lo} + {54'd0, rp_nxt, 2'b00};
        inflight      <= 1'b1;
      end
      if (mem_req_valid && mem_req_ready)
        mem_req_valid <= 1'b0;
      if (cmd_ready && hold_valid)
        hold_valid <= 1'b0;
      if (mem_rsp_valid && inflight && !mem_req_valid) begin
        inflight <= 1'b0;
        drop     <= 1'b0;
        if (!drop) begin
          hold_valid <= 1'b1;
          hold_data  <= mem_rsp_data;
          rp         <= rp_nxt;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          A_BLO:  base_lo   <= reg_wdata;
          A_BHI:  base_hi   <= reg_wdata;
          A_SIZE: size_code <= reg_wdata[1:0];
          A_WP:   wp        <= reg_wdata[PTR_W-1:0];
          A_RP: begin
            rp_rst <= reg_wdata[15];
            if (reg_wdata[15]) begin
              rp <= '0;
              if (inflight) drop <= 1'b1;
            end
          end
          A_CTL:  run_req <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_ring_fetch_chk.sv
module cmd_ring_fetch_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W-1:0] rp,
  input logic [PTR_W-1:0] wp,
  input logic [PTR_W-1:0] rp_mask,
  input logic             rp_rst,
  input logic             run_req,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [63:0]      mem_req_addr,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [31:0]      cmd_data
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3
  rp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rp != $past(rp)) |-> ((rp == '0) || (rp == (($past(rp) + PTR_W'(1)) & $past(rp_mask)))));

  // R4
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> ($past(rp) != $past(wp)));

  // R5
  rst_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> !$past(rp_rst));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_req |=> !$rose(mem_req_valid));

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));
endmodule

bind cmd_ring_fetch cmd_ring_fetch_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rp(rp), .wp(wp), .rp_mask(rp_mask),
  .rp_rst(rp_rst), .run_req(run_req), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data));

// File: tb/tb_cmd_ring_fetch.sv
`timescale 1ns/1ps
module tb_cmd_ring_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        low_power = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'd0;
  logic        cmd_ready = 1'b0;
  logic        cmd_valid;
  logic [31:0] cmd_data;

  cmd_ring_fetch dut (.*);

  always #10 clk = ~clk;

  localparam logic [63:0] BASE = 64'h0000_0002_0000_1000;

  int n_chk = 0, n_bad = 0;
  int lat = 2;
  int req_n = 0, got_n = 0, null_n = 0, null_bad = 0;
  logic [63:0] req_log [0:1023];
  logic [31:0] got_log [0:1023];
  logic        frames_on = 1'b1;
  int          frame_cnt = 0;
  logic        busy = 1'b0;
  int          cnt = 0;
  logic [63:0] paddr = '0;
  int          wd = 0;

  function automatic logic [31:0] mdata(input logic [63:0] a);
    return a[31:0] * 32'h0000_9E37 + 32'h1000_0001;
  endfunction
  function automatic logic [63:0] eaddr(input int idx);
    return BASE + 64'(idx * 4);
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (busy) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mdata(paddr);
        busy <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (mem_req_valid && mem_req_ready) begin
      busy <= 1'b1; paddr <= mem_req_addr; cnt <= lat;
    end
    if (mem_req_valid && mem_req_ready) begin
      req_log[req_n] <= mem_req_addr; req_n <= req_n + 1;
    end
    if (cmd_ready) begin
      if (cmd_valid) begin got_log[got_n] <= cmd_data; got_n <= got_n + 1; end
      else begin null_n <= null_n + 1; if (cmd_data != 0) null_bad <= null_bad + 1; end
    end
  end

  always @(negedge clk) begin
    if (frames_on) frame_cnt <= (frame_cnt + 1) % 8;
    cmd_ready <= frames_on && (frame_cnt == 7);
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 cmd_valid", 64'(cmd_valid), 0);
    chk("R1 cmd_data", 64'(cmd_data), 0);
    chk("R1 mem_req_valid", 64'(mem_req_valid), 0);
    rd(3'd3, v); chk("R1 wp", 64'(v), 0);
    rd(3'd4, v); chk("R1 rp", 64'(v), 0);
    rd(3'd5, v); chk("R1 ctl", 64'(v), 0);
  endtask

  task automatic t_basic;
    logic [31:0] v; int s, g;
    s = req_n; g = got_n;
    wr(3'd0, BASE[31:0]); wr(3'd1, BASE[63:32]); wr(3'd2, 32'd2);
    wr(3'd4, 32'h8000); wr(3'd4, 32'h0);
    wr(3'd5, 32'd1); wr(3'd3, 32'd3);
    cyc(100);
    chk("R2 fetch count", 64'(req_n - s), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R9 R2 fetch addr", req_log[s+i], eaddr(i+1));
      chk("R2 cmd order", 64'(got_log[g+i]), 64'(mdata(eaddr(i+1))));
    end
    rd(3'd4, v); chk("R2 rp after", 64'(v), 3);
    chk("R8 null frames seen", 64'(null_n > 0), 1);
    chk("R8 null is zero", 64'(null_bad), 0);
  endtask

  task automatic t_idle;
    int s; s = req_n;
    cyc(100);
    chk("R4 no fetch when rp==wp", 64'(req_n - s), 0);
  endtask

  task automatic t_wrap;
    logic [31:0] v; int s; s = req_n;
    wr(3'd3, 32'd1);
    cyc(2300);
    chk("R3 wrap count", 64'(req_n - s), 254);
    chk("R3 idx255", req_log[s+251], eaddr(255));
    chk("R3 idx0", req_log[s+252], eaddr(0));
    chk("R3 idx1", req_log[s+253], eaddr(1));
    rd(3'd4, v); chk("R3 rp after wrap", 64'(v), 1);
  endtask

  task automatic t_small;
    logic [31:0] v; int s; s = req_n;
    wr(3'd4, 32'h8000); wr(3'd2, 32'd1); wr(3'd3, 32'd15); wr(3'd4, 32'h0);
    cyc(200);
    wr(3'd3, 32'd2);
    cyc(100);
    chk("R3 small count", 64'(req_n - s), 18);
    chk("R3 small idx15", req_log[s+14], eaddr(15));
    chk("R3 small idx0", req_log[s+15], eaddr(0));
    chk("R3 small idx2", req_log[s+17], eaddr(2));
    rd(3'd4, v); chk("R3 small rp", 64'(v), 2);
  endtask

  task automatic t_rprst;
    logic [31:0] v; int s;
    wr(3'd4, 32'h8000);
    rd(3'd4, v); chk("R5 reset bit reads 1", 64'(v), 64'h8000);
    s = req_n;
    wr(3'd3, 32'd5);
    cyc(60);
    chk("R5 no fetch while reset", 64'(req_n - s), 0);
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R5 reads 0 after clear", 64'(v), 0);
    cyc(100);
    chk("R5 resumes count", 64'(req_n - s), 5);
    chk("R5 resume first addr", req_log[s], eaddr(1));
    rd(3'd4, v); chk("R5 rp after resume", 64'(v), 5);
  endtask

  task automatic t_stop;
    logic [31:0] v; int s; s = req_n;
    lat = 30;
    wr(3'd3, 32'd6);
    cyc(2);
    wr(3'd5, 32'd0);
    rd(3'd5, v); chk("R6 run reads 1 in flight", 64'(v), 1);
    cyc(50);
    rd(3'd5, v); chk("R6 run reads 0 after drain", 64'(v), 0);
    rd(3'd4, v); chk("R6 in-flight entry landed", 64'(v), 6);
    wr(3'd3, 32'd8);
    cyc(100);
    chk("R6 no fetch after stop", 64'(req_n - s), 1);
    lat = 2;
  endtask

  task automatic t_lowpower;
    logic [31:0] v;
    low_power = 1'b1;
    rd(3'd3, v); chk("R7 wp all ones", 64'(v), 64'hFFFF);
    rd(3'd4, v); chk("R7 rp all ones", 64'(v), 64'hFFFF);
    low_power = 1'b0;
    rd(3'd4, v); chk("R7 rp restored", 64'(v), 6);
    rd(3'd3, v); chk("R7 wp restored", 64'(v), 8);
  endtask

  task automatic t_frame;
    logic [31:0] v; int s, g;
    frames_on = 1'b0; cyc(2);
    s = req_n; g = got_n;
    wr(3'd3, 32'd10); wr(3'd5, 32'd1);
    cyc(60);
    chk("R8 one entry held", 64'(req_n - s), 1);
    chk("R8 held valid", 64'(cmd_valid), 1);
    chk("R8 held data", 64'(cmd_data), 64'(mdata(eaddr(7))));
    frames_on = 1'b1;
    cyc(100);
    chk("R8 drained count", 64'(got_n - g), 4);
    chk("R8 last entry", 64'(got_log[g+3]), 64'(mdata(eaddr(10))));
    rd(3'd4, v); chk("R8 rp", 64'(v), 10);
    chk("R8 idle null valid", 64'(cmd_valid), 0);
    chk("R8 idle null data", 64'(cmd_data), 0);
  endtask

  initial begin
    cyc(4); rst_n = 1'b1; cyc(2);
    t_reset; t_basic; t_idle; t_wrap; t_small;
    t_rprst; t_stop; t_lowpower; t_frame;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule